// File: doc/BRIEF.md
# Core Idle-Level Sequencer

This block sits next to one processor core and takes it from normal execution into one of three idle levels, then back out again. Software issues a wait request whose argument names the target level. The sequencer then raises one step request at a time toward helper agents. Each agent is a small handshaking stub that stands in for the pipeline, the clock tree, the cache, the state-save store or the power switch. The sequencer goes on to the next step only after the current agent acknowledges. A deeper level adds more steps: the light halt stops the pipeline and gates most clocks, the middle level also flushes the cache and then gates the rest of the clocks, and the deepest level also saves the architectural state and switches the core rail off.

A wake event walks the same steps backwards. Each request is lowered and the sequencer waits for that agent to release its acknowledge before it moves down to the step below. Deep levels therefore take longer to leave. If a wake arrives during entry, the steps not yet started are skipped and only the work already done is unwound. While the core sits in a level, incoming snoops are passed to the cache until the cache has been flushed. After the flush they are answered directly with a miss.

Top module: `core_idle_seq`

## Requirements
- R1: After reset every step request is low, the level output is 0, busy is low, both clock-gate outputs and the power-off output are low.
- R2: A wait request is taken only while the core is active (level 0, not busy), only when the level field is nonzero, and only when wake is low in the same cycle. Level encoding: 1 = halt, 2 = flushed, 3 = powered off. A request made at any other time, or with level 0, changes nothing.
- R3: Step requests use index 0 = pipeline stop, 1 = clock gate, 2 = cache flush, 3 = state save, 4 = power off. On entry they rise in index order, and request k+1 rises only after acknowledge k has been seen high.
- R4: Level 1 uses steps 0-1, level 2 uses steps 0-2, and level 3 uses steps 0-4. Once all steps of the level are acknowledged, busy falls, level_o shows the level, and no request of a higher index is ever raised.
- R5: clk_gate_o[0] (main clocks) follows the clock-gate step request. clk_gate_o[1] (remaining clocks) is high once the flush step has been acknowledged. pwr_off_o follows the power-off step request and is high only while the save acknowledge is high.
- R6: A wake while resident lowers the requests in descending index order. Each lower request falls only after the acknowledge above it has fallen. Level 0 with busy low is shown only once every acknowledge is low.
- R7: The wake latency, counted from the wake pulse to level 0 with busy low, is strictly larger for level 3 than for level 2, and for level 2 than for level 1.
- R8: A wake during entry drops the in-flight request, never raises the requests of steps not yet started, waits for the in-flight acknowledge to be low, unwinds the completed steps, and returns to level 0.
- R9: A snoop is answered in the same cycle either by forwarding it (snoop_fwd_o) or by a miss (snoop_miss_o), never both. It is forwarded until the flush step has been acknowledged and answered with a miss from then on.
- R10: A wake while the core is active or already unwinding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_valid_i | input | 1 | Wait request strobe |
| wait_level_i | input | 2 | Target idle level of the wait request |
| wake_i | input | 1 | Wake event |
| step_ack_i | input | 5 | Acknowledge from each step agent, level-held |
| step_req_o | output | 5 | Request to each step agent, level-held |
| clk_gate_o | output | 2 | Bit 0: main clocks gated, bit 1: remaining clocks gated |
| pwr_off_o | output | 1 | Core power switch off |
| snoop_valid_i | input | 1 | External snoop arriving |
| snoop_fwd_o | output | 1 | Snoop passed to the cache |
| snoop_miss_o | output | 1 | Snoop answered with a miss |
| level_o | output | 2 | Deepest level whose steps are all complete |
| busy_o | output | 1 | Entry or exit sequence in progress |

## Verification
The hardest case to reach is a wake that lands while an entry step is still waiting for its agent. With fast agents that window is a single cycle or two. The bench therefore gives the flush agent a long response delay. It requests the deepest level, waits until the flush request is seen high with no acknowledge, and only then pulses wake. A cycle-stamped monitor of every request and acknowledge edge then shows that the save and power-off requests never rose, and that the unwinding order and the return to level 0 are correct.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

  localparam int unsigned NSTEP = 5;
  localparam int unsigned LVL_W = 2;
  localparam int unsigned CNT_W = $clog2(NSTEP + 1);

  // step indices, entry order
  localparam int unsigned STP_PIPE  = 0;
  localparam int unsigned STP_CLK   = 1;
  localparam int unsigned STP_FLUSH = 2;
  localparam int unsigned STP_SAVE  = 3;
  localparam int unsigned STP_PWR   = 4;

  typedef enum logic [1:0] {
    M_ACTIVE   = 2'd0,
    M_ENTER    = 2'd1,
    M_RESIDENT = 2'd2,
    M_EXIT     = 2'd3
  } mode_e;

  // number of steps a level needs
  function automatic logic [CNT_W-1:0] steps_for_level(input logic [LVL_W-1:0] lvl);
    case (lvl)
      LVL_W'(1): return CNT_W'(STP_CLK + 1);
      LVL_W'(2): return CNT_W'(STP_FLUSH + 1);
      LVL_W'(3): return CNT_W'(STP_PWR + 1);
      default:   return '0;
    endcase
  endfunction

  // deepest level fully reached with a given number of completed steps
  function automatic logic [LVL_W-1:0] level_for_count(input logic [CNT_W-1:0] c);
    if (c >= CNT_W'(STP_PWR + 1))        return LVL_W'(3);
    else if (c >= CNT_W'(STP_FLUSH + 1)) return LVL_W'(2);
    else if (c >= CNT_W'(STP_CLK + 1))   return LVL_W'(1);
    else                                 return '0;
  endfunction

endpackage

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
  import core_idle_pkg::*;
#(
  parameter int unsigned N_STEPS = core_idle_pkg::NSTEP,
  parameter int unsigned LW      = core_idle_pkg::LVL_W,
  localparam int unsigned CW     = $clog2(N_STEPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wait_valid_i,
  input  logic [LW-1:0]      wait_level_i,
  input  logic               wake_i,
  input  logic [N_STEPS-1:0] step_ack_i,
  output mode_e              mode_o,
  output logic [CW-1:0]      cnt_o,
  output logic               drain_o
);

  mode_e            mode_q, mode_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    depth_q, depth_d;
  logic             drain_q, drain_d;
  logic             upd_en;
  logic [N_STEPS-1:0] cur_sel, prev_sel;
  logic             cur_ack, prev_ack;

  // one-hot select of the step at the counter and the one below it
  for (genvar k = 0; k < N_STEPS; k++) begin : g_sel
    assign cur_sel[k]  = (cnt_q == CW'(k));
    assign prev_sel[k] = (cnt_q == CW'(k + 1));
  end

  assign cur_ack  = |(step_ack_i & cur_sel);
  assign prev_ack = |(step_ack_i & prev_sel);

  always_comb begin
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    depth_d = depth_q;
    drain_d = drain_q;
    case (mode_q)
      M_ACTIVE: begin
        if (wait_valid_i && !wake_i && (wait_level_i != '0)) begin
          mode_d  = M_ENTER;
          depth_d = CW'(steps_for_level(wait_level_i));
          cnt_d   = '0;
        end
      end
      M_ENTER: begin
        if (wake_i) begin
          mode_d = M_EXIT;
          if (cur_ack) cnt_d = cnt_q + 1'b1;
          else         drain_d = 1'b1;
        end else if (cur_ack) begin
          cnt_d = cnt_q + 1'b1;
          if ((cnt_q + 1'b1) == depth_q) mode_d = M_RESIDENT;
        end
      end
      M_RESIDENT: begin
        if (wake_i) mode_d = M_EXIT;
      end
      M_EXIT: begin
        if (drain_q) begin
          if (!cur_ack) drain_d = 1'b0;
        end else if (cnt_q == '0) begin
          mode_d = M_ACTIVE;
        end else if (!prev_ack) begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: mode_d = M_ACTIVE;
    endcase
  end

  assign upd_en = (mode_d != mode_q) || (cnt_d != cnt_q) ||
                  (depth_d != depth_q) || (drain_d != drain_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_ACTIVE;
      cnt_q   <= '0;
      depth_q <= '0;
      drain_q <= 1'b0;
    end else if (upd_en) begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      depth_q <= depth_d;
      drain_q <= drain_d;
    end
  end

  assign mode_o  = mode_q;
  assign cnt_o   = cnt_q;
  assign drain_o = drain_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_RESIDENT) |-> (cnt_q == depth_q && depth_q != '0)); // R4

  AST_RESIDENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_RESIDENT && !wake_i) |=> (mode_q == M_RESIDENT && $stable(cnt_q))); // R2

endmodule

// File: rtl/core_idle_req_gen.sv
module core_idle_req_gen
  import core_idle_pkg::*;
#(
  parameter int unsigned N_STEPS = core_idle_pkg::NSTEP,
  localparam int unsigned CW     = $clog2(N_STEPS + 1)
) (
  input  mode_e              mode_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic               drain_i,
  output logic [N_STEPS-1:0] req_o
);

  logic [CW-1:0] lim;

  // number of low-index requests held high
  always_comb begin
    case (mode_i)
      M_ENTER:    lim = cnt_i + 1'b1;
      M_RESIDENT: lim = cnt_i;
      M_EXIT:     lim = (drain_i || cnt_i == '0) ? cnt_i : cnt_i - 1'b1;
      default:    lim = '0;
    endcase
  end

  for (genvar k = 0; k < N_STEPS; k++) begin : g_req
    assign req_o[k] = (CW'(k) < lim);
  end

endmodule

// File: rtl/core_idle_snoop.sv
module core_idle_snoop (
  input  logic flushed_i,
  input  logic snoop_valid_i,
  output logic snoop_fwd_o,
  output logic snoop_miss_o
);

  assign snoop_fwd_o  = snoop_valid_i && !flushed_i;
  assign snoop_miss_o = snoop_valid_i &&  flushed_i;

endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import core_idle_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wait_valid_i,
  input  logic [LVL_W-1:0] wait_level_i,
  input  logic             wake_i,
  input  logic [NSTEP-1:0] step_ack_i,
  output logic [NSTEP-1:0] step_req_o,
  output logic [1:0]       clk_gate_o,
  output logic             pwr_off_o,
  input  logic             snoop_valid_i,
  output logic             snoop_fwd_o,
  output logic             snoop_miss_o,
  output logic [LVL_W-1:0] level_o,
  output logic             busy_o
);

  mode_e            mode;
  logic [CNT_W-1:0] cnt;
  logic             drain;
  logic             flushed;

  core_idle_fsm #(.N_STEPS(NSTEP), .LW(LVL_W)) fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_valid_i (wait_valid_i),
    .wait_level_i (wait_level_i),
    .wake_i       (wake_i),
    .step_ack_i   (step_ack_i),
    .mode_o       (mode),
    .cnt_o        (cnt),
    .drain_o      (drain)
  );

  core_idle_req_gen #(.N_STEPS(NSTEP)) req_i (
    .mode_i  (mode),
    .cnt_i   (cnt),
    .drain_i (drain),
    .req_o   (step_req_o)
  );

  assign flushed = (cnt >= CNT_W'(STP_FLUSH + 1));

  core_idle_snoop snoop_i (
    .flushed_i     (flushed),
    .snoop_valid_i (snoop_valid_i),
    .snoop_fwd_o   (snoop_fwd_o),
    .snoop_miss_o  (snoop_miss_o)
  );

  assign clk_gate_o = {flushed, step_req_o[STP_CLK]};
  assign pwr_off_o  = step_req_o[STP_PWR];
  assign level_o    = level_for_count(cnt);
  assign busy_o     = (mode == M_ENTER) || (mode == M_EXIT);

  for (genvar k = 1; k < NSTEP; k++) begin : g_chain
    AST_STEP_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_req_o[k] |-> step_ack_i[k-1]); // R3
  end

  AST_PWR_SAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> step_ack_i[STP_SAVE]); // R5

  AST_SNOOP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i |-> (snoop_fwd_o != snoop_miss_o)); // R9

  AST_SNOOP_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && !busy_o && level_o >= LVL_W'(2)) |-> snoop_miss_o); // R9

  AST_ACTIVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && level_o == '0) |-> (step_ack_i == '0 && step_req_o == '0)); // R6

  AST_RISE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(step_req_o & ~$past(step_req_o))) |-> busy_o); // R3

endmodule

// File: tb/core_idle_seq_tb_top.sv
module core_idle_seq_tb_top;

  localparam int NS = 5;

  logic          clk;
  logic          rst_n;
  logic          wait_valid;
  logic [1:0]    wait_level;
  logic          wake;
  logic [NS-1:0] ack;
  logic [NS-1:0] req;
  logic [1:0]    clk_gate;
  logic          pwr_off;
  logic          snoop_valid;
  logic          snoop_fwd;
  logic          snoop_miss;
  logic [1:0]    level;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  int dly [NS];
  int cntr [NS];
  int cyc = 0;
  int req_rise [NS];
  int req_fall [NS];
  int ack_rise [NS];
  int ack_fall [NS];
  int req_rise_n [NS];
  int ack_rise_n [NS];
  logic [NS-1:0] prev_req;
  logic [NS-1:0] prev_ack;
  int lat1, lat2, lat3;

  core_idle_seq dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wait_valid_i  (wait_valid),
    .wait_level_i  (wait_level),
    .wake_i        (wake),
    .step_ack_i    (ack),
    .step_req_o    (req),
    .clk_gate_o    (clk_gate),
    .pwr_off_o     (pwr_off),
    .snoop_valid_i (snoop_valid),
    .snoop_fwd_o   (snoop_fwd),
    .snoop_miss_o  (snoop_miss),
    .level_o       (level),
    .busy_o        (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stub agents: acknowledge follows request after dly+1 cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= '0;
      for (int k = 0; k < NS; k++) cntr[k] <= 0;
    end else begin
      for (int k = 0; k < NS; k++) begin
        if (req[k] != ack[k]) begin
          if (cntr[k] >= dly[k]) begin
            ack[k]  <= req[k];
            cntr[k] <= 0;
          end else cntr[k] <= cntr[k] + 1;
        end else cntr[k] <= 0;
      end
    end
  end

  // edge monitor, sampled shortly after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    for (int k = 0; k < NS; k++) begin
      if (req[k] && !prev_req[k]) begin req_rise[k] = cyc; req_rise_n[k]++; end
      if (!req[k] && prev_req[k]) req_fall[k] = cyc;
      if (ack[k] && !prev_ack[k]) begin ack_rise[k] = cyc; ack_rise_n[k]++; end
      if (!ack[k] && prev_ack[k]) ack_fall[k] = cyc;
    end
    prev_req = req;
    prev_ack = ack;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int k = 0; k < NS; k++) begin
      req_rise[k] = 0; req_fall[k] = 0; ack_rise[k] = 0; ack_fall[k] = 0;
      req_rise_n[k] = 0; ack_rise_n[k] = 0;
    end
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic go_idle(input logic [1:0] lvl);
    @(negedge clk);
    wait_valid = 1'b1; wait_level = lvl;
    @(negedge clk);
    wait_valid = 1'b0; wait_level = 2'd0;
    wait_quiet();
  endtask

  task automatic do_wake(output int lat);
    int start;
    @(negedge clk);
    wake = 1'b1; start = cyc;
    @(negedge clk);
    wake = 1'b0;
    wait_quiet();
    lat = cyc - start;
  endtask

  task automatic t_reset();
    chk("R1 req", int'(req), 0);
    chk("R1 level", int'(level), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 gates", int'({clk_gate, pwr_off}), 0);
  endtask

  task automatic t_halt();
    clear_log();
    go_idle(2'd1);
    chk("R4 halt level", int'(level), 1);
    chk("R4 halt req", int'(req), 5'b00011);
    chk("R5 halt gates", int'({clk_gate, pwr_off}), 3'b010);
    chk("R3 halt order", int'(req_rise[1] > ack_rise[0]), 1);
    chk("R4 halt no flush req", req_rise_n[2], 0);
    snoop_valid = 1'b1; #1;
    chk("R9 halt snoop fwd", int'({snoop_fwd, snoop_miss}), 2'b10);
    snoop_valid = 1'b0;
    do_wake(lat1);
    chk("R6 halt back level", int'(level), 0);
    chk("R6 halt acks clear", int'({ack, req}), 0);
  endtask

  task automatic t_flush();
    clear_log();
    go_idle(2'd2);
    chk("R4 flush level", int'(level), 2);
    chk("R4 flush req", int'(req), 5'b00111);
    chk("R5 flush gates", int'({clk_gate, pwr_off}), 3'b110);
    snoop_valid = 1'b1; #1;
    chk("R9 flush snoop miss", int'({snoop_fwd, snoop_miss}), 2'b01);
    snoop_valid = 1'b0;
    do_wake(lat2);
    chk("R6 flush back", int'({level, busy, ack}), 0);
  endtask

  task automatic t_off();
    clear_log();
    go_idle(2'd3);
    chk("R4 off level", int'(level), 3);
    chk("R4 off req", int'(req), 5'b11111);
    chk("R5 off gates", int'({clk_gate, pwr_off}), 3'b111);
    for (int k = 1; k < NS; k++)
      chk("R3 off entry order", int'(req_rise[k] > ack_rise[k-1]), 1);
    do_wake(lat3);
    for (int k = 0; k < NS - 1; k++)
      chk("R6 off exit order", int'(req_fall[k] > ack_fall[k+1]), 1);
    chk("R6 off back", int'({level, busy, ack, req}), 0);
    chk("R7 latency 3>2", int'(lat3 > lat2), 1);
    chk("R7 latency 2>1", int'(lat2 > lat1), 1);
  endtask

  task automatic t_abort();
    dly[2] = 20;
    clear_log();
    @(negedge clk);
    wait_valid = 1'b1; wait_level = 2'd3;
    @(negedge clk);
    wait_valid = 1'b0; wait_level = 2'd0;
    for (int i = 0; i < 100; i++) begin
      if (req[2]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R8 flush pending", int'({req[2], ack[2]}), 2'b10);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R8 inflight dropped", int'(req[2]), 0);
    wait_quiet();
    chk("R8 save never raised", req_rise_n[3], 0);
    chk("R8 power never raised", req_rise_n[4], 0);
    chk("R8 back to active", int'({level, busy, ack, req}), 0);
    dly[2] = 1;
  endtask

  task automatic t_ignore();
    @(negedge clk);
    wait_valid = 1'b1; wait_level = 2'd0;
    @(negedge clk);
    wait_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 level zero ignored", int'({busy, req}), 0);
    wait_valid = 1'b1; wait_level = 2'd2; wake = 1'b1;
    @(negedge clk);
    wait_valid = 1'b0; wake = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 request with wake ignored", int'({busy, req}), 0);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 wake while active", int'({level, busy, req}), 0);
    snoop_valid = 1'b1; #1;
    chk("R9 active snoop fwd", int'({snoop_fwd, snoop_miss}), 2'b10);
    snoop_valid = 1'b0;
    go_idle(2'd1);
    @(negedge clk);
    wait_valid = 1'b1; wait_level = 2'd3;
    @(negedge clk);
    wait_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 request while resident", int'({level, busy, req}), {2'd1, 1'b0, 5'b00011});
    clear_log();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    wait_quiet();
    chk("R10 wake while unwinding", int'({level, busy, req}), 0);
    chk("R10 no new request", req_rise_n[0] + req_rise_n[1], 0);
  endtask

  initial begin
    for (int k = 0; k < NS; k++) dly[k] = 1;
    clear_log();
    prev_req = '0; prev_ack = '0;
    wait_valid = 1'b0; wait_level = 2'd0; wake = 1'b0; snoop_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_flush();
    t_off();
    t_abort();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule